// File: doc/BRIEF.md
# Exception Entry Frame Sequencer

This block starts exception entry for a processor with a 16-bit data bus and 32-bit addresses. A one-cycle start pulse hands it a vector number (or a software trap number), the current status word, the supervisor stack pointer and the return program counter. The block captures all of these at once. It switches the status word to supervisor mode and lowers the stack pointer by six bytes. It then runs a fixed series of word bus cycles on a request/acknowledge port. Those cycles write a three-word frame, fetch the handler address from the vector table and prefetch the first two handler words.

The first bus request waits out an initial internal cycle whose length the caller picks: 8 half-cycles by default, or 16 when a lengthening input is high at start. The frame words are not written in address order. The low half of the return address goes nearest the old stack top, then the status word at the bottom of the frame, then the high half in between. The handler address is assembled from two vector words, high word first. It appears on an output with a one-cycle done pulse.

Top module: `exc_frame_seq`

## Requirements
- R1: While reset is active and on the first cycle after it is released, `busy_o`, `bus_req_o` and `done_o` are all 0.
- R2: The vector table entry lies at byte address vector*4. Its high word is read first at that address and its low word next at vector*4+2. `new_pc_o` becomes {high word, low word}.
- R3: When `trap_i` is high at start, the vector number used is 32 + `trap_num_i`, and `vector_i` is disregarded.
- R4: The three frame writes occur in this order: the low 16 bits of the return PC to SP-2, the captured status word to SP-6, then the high 16 bits of the return PC to SP-4. SP is `ssp_i` sampled at start, and addresses wrap modulo 2^32.
- R5: From the cycle after an accepted start, `ssp_o` equals the sampled `ssp_i` minus 6, modulo 2^32.
- R6: From the cycle after an accepted start, `sr_o` equals the sampled `status_i` with bit 13 (supervisor) set. The frame holds the sampled value unchanged.
- R7: The first bus request is raised 4 clock cycles after the accepting clock edge when `long_first_i` was 0 at start, and 8 cycles after it when `long_first_i` was 1 (two half-cycles per clock).
- R8: Exactly eight bus cycles run per exception, in this order: one read at the sampled PC, the three writes of R4, the two vector reads of R2, then reads at `new_pc_o` and `new_pc_o`+2.
- R9: `busy_o` is high from the cycle after the accepting edge until the final read is acknowledged. `done_o` is a single-cycle pulse in the cycle after that acknowledge, with `busy_o` already low and `new_pc_o` valid.
- R10: A start pulse while `busy_o` is high has no effect: no extra done pulse, no change to `ssp_o`, and no change to the bus sequence.
- R11: While `bus_req_o` is high and `bus_ack_i` is low, address, write enable and write data stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin exception entry (accepted when idle) |
| trap_i | input | 1 | Use trap numbering instead of `vector_i` |
| trap_num_i | input | 4 | Software trap number |
| vector_i | input | 8 | Exception vector number |
| status_i | input | 16 | Status word before entry |
| ssp_i | input | 32 | Supervisor stack pointer before entry |
| pc_i | input | 32 | Return address to push |
| long_first_i | input | 1 | Lengthen the initial internal cycle to 16 half-cycles |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final prefetch |
| new_pc_o | output | 32 | Handler address from the vector table |
| sr_o | output | 16 | Status word with supervisor bit set |
| ssp_o | output | 32 | Stack pointer after the frame is allocated |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | 1 = word write, 0 = word read |
| bus_addr_o | output | 32 | Byte address of the word |
| bus_wdata_o | output | 16 | Write data |
| bus_ack_i | input | 1 | Bus cycle complete (read data valid) |
| bus_rdata_i | input | 16 | Read data |

## Verification
`ssp_o`, `sr_o` and `busy_o` are due one edge after the accepting edge, so the bench samples them on the falling edge right after it lowers start. The first request is due 4 or 8 edges later. The bench timestamps it with a cycle counter and compares the difference against the selected length. `done_o` is due exactly one edge after the last acknowledge, which the bench checks by comparing the stamped cycles. A bus model answers with 0 to 3 random wait states, so every recorded bus operation is compared in order once the run ends.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;

  localparam int unsigned SUPER_BIT = 13;
  localparam int unsigned NUM_OPS   = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_BUS} state_e;

  typedef enum logic [2:0] {
    AS_PC, AS_SPM2, AS_SPM6, AS_SPM4, AS_VHI, AS_VLO, AS_NPC, AS_NPC2
  } asel_e;

  typedef enum logic [1:0] {DS_PCLO, DS_SR, DS_PCHI, DS_NONE} dsel_e;

  typedef struct packed {
    logic  we;
    asel_e asel;
    dsel_e dsel;
  } bus_op_t;

  // Fixed entry program; the frame write order is part of the behaviour.
  function automatic bus_op_t op_at(input logic [2:0] idx);
    bus_op_t o;
    case (idx)
      3'd0:    o = '{we: 1'b0, asel: AS_PC,   dsel: DS_NONE};
      3'd1:    o = '{we: 1'b1, asel: AS_SPM2, dsel: DS_PCLO};
      3'd2:    o = '{we: 1'b1, asel: AS_SPM6, dsel: DS_SR};
      3'd3:    o = '{we: 1'b1, asel: AS_SPM4, dsel: DS_PCHI};
      3'd4:    o = '{we: 1'b0, asel: AS_VHI,  dsel: DS_NONE};
      3'd5:    o = '{we: 1'b0, asel: AS_VLO,  dsel: DS_NONE};
      3'd6:    o = '{we: 1'b0, asel: AS_NPC,  dsel: DS_NONE};
      default: o = '{we: 1'b0, asel: AS_NPC2, dsel: DS_NONE};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel #(
  parameter int unsigned VW        = 8,
  parameter int unsigned AW        = 32,
  parameter int unsigned TRAP_BASE = 32
) (
  input  logic          trap_i,
  input  logic [3:0]    trap_num_i,
  input  logic [VW-1:0] vector_i,
  output logic [AW-1:0] vaddr_o
);
  logic [VW-1:0] vec;

  always_comb begin
    if (trap_i) vec = VW'(TRAP_BASE) + VW'(trap_num_i);
    else        vec = vector_i;
    vaddr_o = AW'(vec) << 2;
  end
endmodule

// File: rtl/exc_delay_ctr.sv
module exc_delay_ctr #(
  parameter int unsigned SHORT_CLK = 4,
  parameter int unsigned LONG_CLK  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  output logic zero_o
);
  localparam int unsigned CW = $clog2(LONG_CLK + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= long_i ? CW'(LONG_CLK - 1) : CW'(SHORT_CLK - 1);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/exc_bus_mux.sv
module exc_bus_mux
  import exc_frame_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input  logic [2:0]    idx_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] vaddr_i,
  input  logic [AW-1:0] npc_i,
  input  logic [DW-1:0] sr_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  bus_op_t op;

  always_comb begin
    op   = op_at(idx_i);
    we_o = op.we;
    unique case (op.asel)
      AS_PC:   addr_o = pc_i;
      AS_SPM2: addr_o = sp_i - AW'(2);
      AS_SPM6: addr_o = sp_i - AW'(6);
      AS_SPM4: addr_o = sp_i - AW'(4);
      AS_VHI:  addr_o = vaddr_i;
      AS_VLO:  addr_o = vaddr_i + AW'(2);
      AS_NPC:  addr_o = npc_i;
      default: addr_o = npc_i + AW'(2);
    endcase
    unique case (op.dsel)
      DS_PCLO: wdata_o = pc_i[DW-1:0];
      DS_SR:   wdata_o = sr_i;
      DS_PCHI: wdata_o = pc_i[2*DW-1:DW];
      default: wdata_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_frame_pkg::*;
#(
  parameter int unsigned AW           = 32,
  parameter int unsigned DW           = 16,
  parameter int unsigned VW           = 8,
  parameter int unsigned TRAP_BASE    = 32,
  parameter int unsigned SHORT_HALF   = 8,
  parameter int unsigned LONG_HALF    = 16,
  parameter int unsigned HALF_PER_CLK = 2,
  parameter int unsigned FRAME_BYTES  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          trap_i,
  input  logic [3:0]    trap_num_i,
  input  logic [VW-1:0] vector_i,
  input  logic [DW-1:0] status_i,
  input  logic [AW-1:0] ssp_i,
  input  logic [AW-1:0] pc_i,
  input  logic          long_first_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] new_pc_o,
  output logic [DW-1:0] sr_o,
  output logic [AW-1:0] ssp_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i
);
  localparam int unsigned SHORT_CLK = SHORT_HALF / HALF_PER_CLK;
  localparam int unsigned LONG_CLK  = LONG_HALF / HALF_PER_CLK;
  localparam logic [2:0]  IDX_VHI   = 3'd4;
  localparam logic [2:0]  IDX_VLO   = 3'd5;
  localparam logic [2:0]  IDX_LAST  = 3'(NUM_OPS - 1);

  state_e        state_q;
  logic [2:0]    idx_q;
  logic [AW-1:0] pc_q, sp_q, vaddr_q, npc_q, ssp_q;
  logic [DW-1:0] sr_cap_q, sr_q, vhi_q;
  logic          done_q;
  logic          accept, delay_zero;
  logic [AW-1:0] vaddr;

  assign accept = start_i && (state_q == ST_IDLE);

  exc_vec_sel #(.VW(VW), .AW(AW), .TRAP_BASE(TRAP_BASE)) u_vec (
    .trap_i     (trap_i),
    .trap_num_i (trap_num_i),
    .vector_i   (vector_i),
    .vaddr_o    (vaddr)
  );

  exc_delay_ctr #(.SHORT_CLK(SHORT_CLK), .LONG_CLK(LONG_CLK)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .long_i (long_first_i),
    .zero_o (delay_zero)
  );

  exc_bus_mux #(.AW(AW), .DW(DW)) u_mux (
    .idx_i   (idx_q),
    .pc_i    (pc_q),
    .sp_i    (sp_q),
    .vaddr_i (vaddr_q),
    .npc_i   (npc_q),
    .sr_i    (sr_cap_q),
    .we_o    (bus_we_o),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      pc_q     <= '0;
      sp_q     <= '0;
      vaddr_q  <= '0;
      npc_q    <= '0;
      ssp_q    <= '0;
      sr_cap_q <= '0;
      sr_q     <= '0;
      vhi_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          pc_q     <= pc_i;
          sp_q     <= ssp_i;
          vaddr_q  <= vaddr;
          sr_cap_q <= status_i;
          sr_q     <= status_i | DW'(1 << SUPER_BIT);
          ssp_q    <= ssp_i - AW'(FRAME_BYTES);
          idx_q    <= '0;
          state_q  <= ST_DELAY;
        end
        ST_DELAY: if (delay_zero) state_q <= ST_BUS;
        default: if (bus_ack_i) begin
          if (idx_q == IDX_VHI) vhi_q <= bus_rdata_i;
          if (idx_q == IDX_VLO) npc_q <= AW'({vhi_q, bus_rdata_i});
          if (idx_q == IDX_LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign bus_req_o = (state_q == ST_BUS);
  assign done_o    = done_q;
  assign new_pc_o  = npc_q;
  assign sr_o      = sr_q;
  assign ssp_o     = ssp_q;
endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] ssp_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] sr_o,
  input logic [AW-1:0] ssp_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_ack_i
);
  a_r11_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)
                                 && $stable(bus_wdata_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);

  a_r6_super_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> sr_o[13]);

  a_r5_frame_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && (ssp_o == $past(ssp_i) - AW'(6)));

  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o |=> $stable(ssp_o));

  a_r7_no_early_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> !bus_req_o);
endmodule

bind exc_frame_seq exc_frame_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .ssp_i       (ssp_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .sr_o        (sr_o),
  .ssp_o       (ssp_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/exc_frame_seq_test.sv
module exc_frame_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        trap_i = 1'b0;
  logic [3:0]  trap_num_i = '0;
  logic [7:0]  vector_i = '0;
  logic [15:0] status_i = '0;
  logic [31:0] ssp_i = '0;
  logic [31:0] pc_i = '0;
  logic        long_first_i = 1'b0;
  logic        busy_o, done_o, bus_req_o, bus_we_o;
  logic [31:0] new_pc_o, ssp_o, bus_addr_o;
  logic [15:0] sr_o, bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [15:0] bus_rdata_i = '0;

  exc_frame_seq uut (.*);

  always #10 clk_i = ~clk_i;

  int unsigned cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bus model state
  logic [15:0] mem [logic [31:0]];
  int unsigned wait_cnt = 0;
  bit          hold_pend = 0;
  logic [31:0] h_addr;
  logic        h_we;
  logic [15:0] h_wd;
  int          n_ops = 0;
  logic        lg_we   [16];
  logic [31:0] lg_addr [16];
  logic [15:0] lg_wd   [16];
  bit          seen_req = 0;
  int unsigned first_req_cyc = 0, last_ack_cyc = 0, done_cyc = 0;
  int          done_cnt = 0;
  logic [31:0] done_pc;
  logic        done_busy;

  function automatic logic [15:0] rd_word(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[15:0] ^ 16'h5a5a;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o) begin
        done_cnt++;
        done_cyc  = cyc;
        done_pc   = new_pc_o;
        done_busy = busy_o;
      end
      if (bus_req_o) begin
        if (!seen_req) begin
          seen_req      = 1;
          first_req_cyc = cyc;
        end
        if (hold_pend)
          chk(bus_addr_o == h_addr && bus_we_o == h_we && bus_wdata_o == h_wd,
              "R11 hold", {bus_we_o, bus_addr_o, bus_wdata_o}, {h_we, h_addr, h_wd});
        if (wait_cnt == 0) begin
          bus_ack_i   = 1'b1;
          bus_rdata_i = rd_word(bus_addr_o);
          if (bus_we_o) mem[bus_addr_o] = bus_wdata_o;
          if (n_ops < 16) begin
            lg_we[n_ops]   = bus_we_o;
            lg_addr[n_ops] = bus_addr_o;
            lg_wd[n_ops]   = bus_wdata_o;
          end
          n_ops++;
          last_ack_cyc = cyc;
          wait_cnt     = $urandom_range(0, 3);
          hold_pend    = 0;
        end else begin
          bus_ack_i = 1'b0;
          wait_cnt--;
          hold_pend = 1;
          h_addr    = bus_addr_o;
          h_we      = bus_we_o;
          h_wd      = bus_wdata_o;
        end
      end else begin
        bus_ack_i = 1'b0;
        hold_pend = 0;
      end
    end
  end

  task automatic run_exc(input bit trap, input logic [3:0] tnum, input logic [7:0] vec,
                         input logic [15:0] sr, input logic [31:0] ssp,
                         input logic [31:0] pc, input bit lng, input bit inject);
    logic [7:0]  evec;
    logic [31:0] vaddr, npc;
    logic [15:0] vhi, vlo;
    logic        e_we [8];
    logic [31:0] e_ad [8];
    logic [15:0] e_wd [8];
    int unsigned start_cyc;

    evec  = trap ? (8'd32 + {4'd0, tnum}) : vec;
    vaddr = {22'd0, evec, 2'b00};
    vhi   = 16'($urandom()) & 16'hfffe;
    vlo   = 16'($urandom()) & 16'hfffe;
    mem[vaddr]         = vhi;
    mem[vaddr + 32'd2] = vlo;
    npc = {vhi, vlo};

    e_we = '{0, 1, 1, 1, 0, 0, 0, 0};
    e_ad[0] = pc;               e_wd[0] = 16'h0;
    e_ad[1] = ssp - 32'd2;      e_wd[1] = pc[15:0];
    e_ad[2] = ssp - 32'd6;      e_wd[2] = sr;
    e_ad[3] = ssp - 32'd4;      e_wd[3] = pc[31:16];
    e_ad[4] = vaddr;            e_wd[4] = 16'h0;
    e_ad[5] = vaddr + 32'd2;    e_wd[5] = 16'h0;
    e_ad[6] = npc;              e_wd[6] = 16'h0;
    e_ad[7] = npc + 32'd2;      e_wd[7] = 16'h0;

    n_ops = 0; done_cnt = 0; seen_req = 0;

    @(negedge clk_i);
    trap_i = trap; trap_num_i = tnum; vector_i = vec; status_i = sr;
    ssp_i = ssp; pc_i = pc; long_first_i = lng; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    start_cyc = cyc;
    vector_i = ~vec; ssp_i = ~ssp; status_i = ~sr; pc_i = ~pc;
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    chk(ssp_o == ssp - 32'd6, "R5 ssp_o", ssp_o, ssp - 32'd6);
    chk(sr_o == (sr | 16'h2000), "R6 sr_o", sr_o, sr | 16'h2000);

    if (inject) begin
      repeat (2) @(negedge clk_i);
      start_i = 1'b1; vector_i = 8'h07; trap_i = 1'b0; ssp_i = 32'h0000_2000;
      @(negedge clk_i);
      start_i = 1'b0;
      @(negedge clk_i);
      chk(ssp_o == ssp - 32'd6, "R10 ssp_o unchanged", ssp_o, ssp - 32'd6);
    end

    while (done_cnt == 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);

    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(done_busy == 1'b0, "R9 busy low at done", done_busy, 0);
    chk(done_cyc == last_ack_cyc + 1, "R9 done timing", done_cyc, last_ack_cyc + 1);
    chk(done_pc == npc, "R2 new_pc", done_pc, npc);
    chk(first_req_cyc - start_cyc == (lng ? 8 : 4), "R7 first request delay",
        first_req_cyc - start_cyc, lng ? 8 : 4);
    chk(n_ops == 8, "R8 op count", n_ops, 8);
    for (int i = 0; i < 8; i++) begin
      if (i >= 1 && i <= 3)
        chk(lg_we[i] == 1'b1 && lg_addr[i] == e_ad[i] && lg_wd[i] == e_wd[i],
            (i == 2) ? "R4 R6 frame status write" : "R4 frame write",
            {lg_we[i], lg_addr[i], lg_wd[i]}, {e_we[i], e_ad[i], e_wd[i]});
      else
        chk(lg_we[i] == 1'b0 && lg_addr[i] == e_ad[i],
            (i == 4 || i == 5) ? (trap ? "R3 R2 vector read" : "R2 vector read")
                               : "R8 read order",
            {lg_we[i], lg_addr[i]}, {e_we[i], e_ad[i]});
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    chk(busy_o == 0 && bus_req_o == 0 && done_o == 0, "R1 in reset",
        {busy_o, bus_req_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 0 && bus_req_o == 0 && done_o == 0, "R1 after reset",
        {busy_o, bus_req_o, done_o}, 0);

    run_exc(0, 4'd0, 8'd6,   16'h0715, 32'h0001_0000, 32'h0000_4ab2, 0, 0);
    run_exc(1, 4'd15, 8'd3,  16'h2700, 32'h0002_0100, 32'h00fe_1234, 1, 0);
    run_exc(1, 4'd0, 8'd99,  16'h001f, 32'h0003_0000, 32'h1234_5678, 0, 0);
    run_exc(0, 4'd0, 8'd255, 16'hffff, 32'h0000_0004, 32'hffff_fffe, 1, 0);
    run_exc(0, 4'd0, 8'd24,  16'h0000, 32'h0004_0000, 32'h0000_1000, 0, 1);
    run_exc(1, 4'd9, 8'd0,   16'h8004, 32'h0005_0000, 32'h0010_0020, 1, 1);
    for (int n = 0; n < 24; n++)
      run_exc(1'($urandom()), 4'($urandom()), 8'($urandom()), 16'($urandom()),
              32'h0001_0000 + (($urandom() & 32'h000f_fffe)),
              $urandom() & 32'hffff_fffe, 1'($urandom()), 1'($urandom()));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule